// File: doc/BRIEF.md
# UART Channel Status Word

This block collects the condition of one UART channel into a single 32-bit read-only status word. The receiver, transmitter and their FIFOs report through single-cycle event pulses and level signals. The block turns these into sticky flags, live images and readiness bits. Software-facing control logic issues clear commands as single-cycle strobes. The bus interface asserts a read strobe when it reads the word.

There are several ways to clear a flag, and each flag listens only to its own:

- A general clear command covers six receive-error and event flags.
- The negative-acknowledge flag and the repetition-limit flag each have a dedicated clear.
- The clear-to-send change flag clears when the word is read.
- The transmit-ready and transmit-empty flags drop when the transmit holding register is written.
- The receive-ready flag drops when the receive holding register is read.

The two ready bits follow different rules depending on whether the FIFOs are enabled.

A read captures the word into `rd_data` at the strobe edge, so the bus sees the value from before any clear caused by that same read. The word carries no data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level or a single-cycle strobe.

Top module: `uart_stat_word`

## Requirements
- R1: After reset `status_word` is zero. The used bit positions are 24 Manchester error, 23 CTS level, 22 compare match, 19 CTS change, 13 NACK, 10 repetition limit, 9 transmitter empty, 8 timeout, 7 parity, 6 framing, 5 overrun, 2 break, 1 TX ready and 0 RX ready. Every other bit always reads 0.
- R2: The event pulses for Manchester, compare, parity, framing, overrun and break each set their bit on the next clock edge. The bit then holds until `cmd_clr_status` is issued, and no other command clears it. An event arriving in the same cycle as the clear leaves its bit set.
- R3: The NACK bit (13) is cleared only by `cmd_clr_nack`, and the repetition-limit bit (10) only by `cmd_clr_iter`. In both cases a same-cycle event wins over the clear.
- R4: `cts_in` passes through two synchronizer flops, so bit 23 shows its level two edges after a change. Bit 19 sets one edge later on either edge direction. Bit 19 clears on the edge that samples `rd_strobe`, unless an edge is detected in that same cycle; in that case it stays set.
- R5: Bit 8 sets on `ev_timeout` and clears on `cmd_start_timeout`. It is held at 0 while `tout_reload_zero` is high.
- R6: Bit 9 is 1 one edge after the following all hold: the transmitter is enabled, the holding register and shift register are both empty, and no `thr_write` occurs. It is 0 while the transmitter is disabled.
- R7: With `fifo_mode` low, bit 1 is 1 one edge after the transmitter is enabled with an empty holding register. It is 0 after a `thr_write`, while a character is held, while a break is pending, or while the transmitter is disabled.
- R8: With `fifo_mode` high, bit 1 is the inverse of `tx_fifo_full` one edge later, whatever the enable state.
- R9: With `fifo_mode` low, a completed character arms a pending flag and `rhr_read` clears it; a same-cycle completion wins over the read. Bit 0 shows the pending flag ANDed with `rx_enable`, one edge later, so a character received while disabled appears when the receiver is enabled.
- R10: With `fifo_mode` high, bit 0 is the inverse of `rx_fifo_empty` one edge later.
- R11: On the edge that samples `rd_strobe`, `rd_data` captures `status_word` as it stood before that edge. Without a strobe, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_manch_err | input | 1 | Manchester decoding error pulse |
| ev_cmp_match | input | 1 | Received character matched compare criteria |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_frame_err | input | 1 | Low stop bit pulse |
| ev_overrun | input | 1 | Overrun pulse |
| ev_break | input | 1 | Break start or end pulse |
| ev_nack | input | 1 | Negative acknowledge pulse |
| ev_iter_limit | input | 1 | Repetition limit reached pulse |
| ev_timeout | input | 1 | Receiver timeout expiry pulse |
| tout_reload_zero | input | 1 | Timeout reload value is zero |
| cmd_clr_status | input | 1 | General status clear strobe |
| cmd_clr_nack | input | 1 | NACK clear strobe |
| cmd_clr_iter | input | 1 | Repetition-limit clear strobe |
| cmd_start_timeout | input | 1 | Start-timeout strobe |
| cts_in | input | 1 | Asynchronous clear-to-send input |
| fifo_mode | input | 1 | FIFOs enabled |
| tx_enable | input | 1 | Transmitter enabled |
| tx_hold_full | input | 1 | Transmit holding register (or FIFO) not empty |
| tx_shift_busy | input | 1 | Transmit shift register holds a character |
| tx_brk_pending | input | 1 | Break transmission requested |
| thr_write | input | 1 | Write strobe to transmit holding register |
| tx_fifo_full | input | 1 | Transmit FIFO full |
| rx_enable | input | 1 | Receiver enabled |
| rx_char_done | input | 1 | Complete character received pulse |
| rhr_read | input | 1 | Read strobe of receive holding register |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| rd_strobe | input | 1 | Status word read strobe |
| status_word | output | 32 | Live status word |
| rd_data | output | 32 | Word captured at the last read strobe |

## Verification
The main case is a flag's set event landing in the same cycle as its clear. The bench provokes this for three flags:

- a framing error together with the general clear;
- a repetition-limit event together with its own clear;
- a CTS edge arriving while `rd_strobe` is high.

In each case it expects the flag to survive. For the read collision it also expects `rd_data` to show the value from before the event. A similar collision on the receive side pairs a character completion with a holding-register read, and bit 0 must stay 1.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int STAT_W    = 32;
  localparam int B_MANCH   = 24;
  localparam int B_CTS     = 23;
  localparam int B_CMP     = 22;
  localparam int B_CTSCHG  = 19;
  localparam int B_NACK    = 13;
  localparam int B_ITER    = 10;
  localparam int B_TXEMPTY = 9;
  localparam int B_TOUT    = 8;
  localparam int B_PAR     = 7;
  localparam int B_FRM     = 6;
  localparam int B_OVR     = 5;
  localparam int B_BRK     = 2;
  localparam int B_TXRDY   = 1;
  localparam int B_RXRDY   = 0;

  // flags cleared by the general clear command
  localparam int N_GEN = 6;
  typedef enum logic [2:0] {
    GF_MANCH = 3'd0,
    GF_CMP   = 3'd1,
    GF_PAR   = 3'd2,
    GF_FRM   = 3'd3,
    GF_OVR   = 3'd4,
    GF_BRK   = 3'd5
  } gen_flag_e;

  function automatic int gen_pos(input int idx);
    case (idx)
      0:       return B_MANCH;
      1:       return B_CMP;
      2:       return B_PAR;
      3:       return B_FRM;
      4:       return B_OVR;
      default: return B_BRK;
    endcase
  endfunction

  localparam logic [STAT_W-1:0] USED_MASK =
    (STAT_W'(1) << B_MANCH) | (STAT_W'(1) << B_CTS) | (STAT_W'(1) << B_CMP) |
    (STAT_W'(1) << B_CTSCHG) | (STAT_W'(1) << B_NACK) | (STAT_W'(1) << B_ITER) |
    (STAT_W'(1) << B_TXEMPTY) | (STAT_W'(1) << B_TOUT) | (STAT_W'(1) << B_PAR) |
    (STAT_W'(1) << B_FRM) | (STAT_W'(1) << B_OVR) | (STAT_W'(1) << B_BRK) |
    (STAT_W'(1) << B_TXRDY) | (STAT_W'(1) << B_RXRDY);
endpackage

// File: rtl/uart_stat_sticky.sv
// Bank of sticky flags sharing one clear; a set in the clear cycle wins.
module uart_stat_sticky #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= set_i | (clr_i ? '0 : q_r);
  end

  assign q_o = q_r;
endmodule

// File: rtl/uart_stat_cts.sv
// Synchronizer, live level image and read-cleared change flag for CTS.
module uart_stat_cts #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_in,
  input  logic rd_strobe,
  output logic level_o,
  output logic chg_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_r;
  logic          prev_r;
  logic          chg_r;
  logic          edge_w;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_r <= '0;
        else        sync_r <= cts_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_r <= '0;
        else        sync_r <= {sync_r[LAST-1:0], cts_in};
      end
    end
  endgenerate

  assign edge_w = sync_r[LAST] ^ prev_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_r <= 1'b0;
      chg_r  <= 1'b0;
    end else begin
      prev_r <= sync_r[LAST];
      if (edge_w)         chg_r <= 1'b1;
      else if (rd_strobe) chg_r <= 1'b0;
    end
  end

  assign level_o = sync_r[LAST];
  assign chg_o   = chg_r;
endmodule

// File: rtl/uart_stat_ready.sv
// Transmit empty, transmit ready and receive ready flags, all registered.
module uart_stat_ready (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic tx_enable,
  input  logic tx_hold_full,
  input  logic tx_shift_busy,
  input  logic tx_brk_pending,
  input  logic thr_write,
  input  logic tx_fifo_full,
  input  logic rx_enable,
  input  logic rx_char_done,
  input  logic rhr_read,
  input  logic rx_fifo_empty,
  output logic txempty_o,
  output logic txrdy_o,
  output logic rxrdy_o
);
  logic txempty_r, txrdy_r, rxrdy_r, rx_pend_r;
  logic rx_pend_n, hold_free;

  assign hold_free = tx_enable & ~tx_hold_full & ~thr_write;
  assign rx_pend_n = rx_char_done | (rhr_read ? 1'b0 : rx_pend_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txempty_r <= 1'b0;
      txrdy_r   <= 1'b0;
      rxrdy_r   <= 1'b0;
      rx_pend_r <= 1'b0;
    end else begin
      txempty_r <= hold_free & ~tx_shift_busy;
      txrdy_r   <= fifo_mode ? ~tx_fifo_full : (hold_free & ~tx_brk_pending);
      rx_pend_r <= rx_pend_n;
      rxrdy_r   <= fifo_mode ? ~rx_fifo_empty : (rx_enable & rx_pend_n);
    end
  end

  assign txempty_o = txempty_r;
  assign txrdy_o   = txrdy_r;
  assign rxrdy_o   = rxrdy_r;
endmodule

// File: rtl/uart_stat_word.sv
module uart_stat_word
  import uart_stat_pkg::*;
#(
  parameter int CTS_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_manch_err,
  input  logic              ev_cmp_match,
  input  logic              ev_parity_err,
  input  logic              ev_frame_err,
  input  logic              ev_overrun,
  input  logic              ev_break,
  input  logic              ev_nack,
  input  logic              ev_iter_limit,
  input  logic              ev_timeout,
  input  logic              tout_reload_zero,
  input  logic              cmd_clr_status,
  input  logic              cmd_clr_nack,
  input  logic              cmd_clr_iter,
  input  logic              cmd_start_timeout,
  input  logic              cts_in,
  input  logic              fifo_mode,
  input  logic              tx_enable,
  input  logic              tx_hold_full,
  input  logic              tx_shift_busy,
  input  logic              tx_brk_pending,
  input  logic              thr_write,
  input  logic              tx_fifo_full,
  input  logic              rx_enable,
  input  logic              rx_char_done,
  input  logic              rhr_read,
  input  logic              rx_fifo_empty,
  input  logic              rd_strobe,
  output logic [STAT_W-1:0] status_word,
  output logic [STAT_W-1:0] rd_data
);
  logic [N_GEN-1:0] gen_set, gen_q;
  logic             nack_q, iter_q, tout_r;
  logic             cts_lvl, cts_chg;
  logic             txempty, txrdy, rxrdy;
  logic [STAT_W-1:0] word_w, rd_r;

  always_comb begin
    gen_set           = '0;
    gen_set[GF_MANCH] = ev_manch_err;
    gen_set[GF_CMP]   = ev_cmp_match;
    gen_set[GF_PAR]   = ev_parity_err;
    gen_set[GF_FRM]   = ev_frame_err;
    gen_set[GF_OVR]   = ev_overrun;
    gen_set[GF_BRK]   = ev_break;
  end

  uart_stat_sticky #(.WIDTH(N_GEN)) u_gen (
    .clk(clk), .rst_n(rst_n), .set_i(gen_set), .clr_i(cmd_clr_status), .q_o(gen_q));

  uart_stat_sticky #(.WIDTH(1)) u_nack (
    .clk(clk), .rst_n(rst_n), .set_i(ev_nack), .clr_i(cmd_clr_nack), .q_o(nack_q));

  uart_stat_sticky #(.WIDTH(1)) u_iter (
    .clk(clk), .rst_n(rst_n), .set_i(ev_iter_limit), .clr_i(cmd_clr_iter), .q_o(iter_q));

  // timeout: zero reload forces clear, else expiry beats restart
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tout_r <= 1'b0;
    else if (tout_reload_zero)  tout_r <= 1'b0;
    else if (ev_timeout)        tout_r <= 1'b1;
    else if (cmd_start_timeout) tout_r <= 1'b0;
  end

  uart_stat_cts #(.STAGES(CTS_STAGES)) u_cts (
    .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .rd_strobe(rd_strobe),
    .level_o(cts_lvl), .chg_o(cts_chg));

  uart_stat_ready u_rdy (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .tx_enable(tx_enable), .tx_hold_full(tx_hold_full), .tx_shift_busy(tx_shift_busy),
    .tx_brk_pending(tx_brk_pending), .thr_write(thr_write), .tx_fifo_full(tx_fifo_full),
    .rx_enable(rx_enable), .rx_char_done(rx_char_done), .rhr_read(rhr_read),
    .rx_fifo_empty(rx_fifo_empty),
    .txempty_o(txempty), .txrdy_o(txrdy), .rxrdy_o(rxrdy));

  always_comb begin
    word_w = '0;
    for (int i = 0; i < N_GEN; i++) word_w[gen_pos(i)] = gen_q[i];
    word_w[B_NACK]    = nack_q;
    word_w[B_ITER]    = iter_q;
    word_w[B_TOUT]    = tout_r;
    word_w[B_CTS]     = cts_lvl;
    word_w[B_CTSCHG]  = cts_chg;
    word_w[B_TXEMPTY] = txempty;
    word_w[B_TXRDY]   = txrdy;
    word_w[B_RXRDY]   = rxrdy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_r <= '0;
    else if (rd_strobe) rd_r <= word_w;
  end

  assign status_word = word_w;
  assign rd_data     = rd_r;
endmodule

// File: rtl/uart_stat_chk.sv
module uart_stat_chk
  import uart_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_overrun,
  input logic              cmd_clr_status,
  input logic              cmd_clr_nack,
  input logic              cmd_clr_iter,
  input logic              tout_reload_zero,
  input logic              cts_in,
  input logic              fifo_mode,
  input logic              tx_enable,
  input logic              thr_write,
  input logic              tx_fifo_full,
  input logic              rx_fifo_empty,
  input logic              rd_strobe,
  input logic [STAT_W-1:0] status_word,
  input logic [STAT_W-1:0] rd_data
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & ~USED_MASK) == '0); // R1
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> status_word[B_OVR]); // R2
  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[B_PAR] && !cmd_clr_status |=> status_word[B_PAR]); // R2
  AST_NACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[B_NACK] && !cmd_clr_nack |=> status_word[B_NACK]); // R3
  AST_ITER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[B_ITER] && !cmd_clr_iter |=> status_word[B_ITER]); // R3
  AST_CTS_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst == 2'd3 |-> status_word[B_CTS] == $past(cts_in, 2)); // R4
  AST_TOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tout_reload_zero |=> !status_word[B_TOUT]); // R5
  AST_TXE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> !status_word[B_TXEMPTY]); // R6
  AST_TXR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode && thr_write |=> !status_word[B_TXRDY]); // R7
  AST_TXR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && tx_fifo_full |=> !status_word[B_TXRDY]); // R8
  AST_RXR_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && !rx_fifo_empty |=> status_word[B_RXRDY]); // R10
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> rd_data == $past(status_word)); // R11
endmodule

bind uart_stat_word uart_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_overrun(ev_overrun), .cmd_clr_status(cmd_clr_status),
  .cmd_clr_nack(cmd_clr_nack), .cmd_clr_iter(cmd_clr_iter),
  .tout_reload_zero(tout_reload_zero), .cts_in(cts_in), .fifo_mode(fifo_mode),
  .tx_enable(tx_enable), .thr_write(thr_write), .tx_fifo_full(tx_fifo_full),
  .rx_fifo_empty(rx_fifo_empty), .rd_strobe(rd_strobe),
  .status_word(status_word), .rd_data(rd_data));

// File: tb/uart_stat_word_test.sv
module uart_stat_word_test;
  localparam logic [31:0] MANCH = 32'h1 << 24, CTS = 32'h1 << 23, CMP = 32'h1 << 22;
  localparam logic [31:0] CHG = 32'h1 << 19, NACK = 32'h1 << 13, ITER = 32'h1 << 10;
  localparam logic [31:0] TXE = 32'h1 << 9, TOUT = 32'h1 << 8, PAR = 32'h1 << 7;
  localparam logic [31:0] FRM = 32'h1 << 6, OVR = 32'h1 << 5, BRK = 32'h1 << 2;
  localparam logic [31:0] TXR = 32'h1 << 1, RXR = 32'h1;
  localparam logic [31:0] GEN = MANCH | CMP | PAR | FRM | OVR | BRK;
  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic ev_manch_err = 0, ev_cmp_match = 0, ev_parity_err = 0, ev_frame_err = 0;
  logic ev_overrun = 0, ev_break = 0, ev_nack = 0, ev_iter_limit = 0, ev_timeout = 0;
  logic tout_reload_zero = 0, cmd_clr_status = 0, cmd_clr_nack = 0, cmd_clr_iter = 0;
  logic cmd_start_timeout = 0, cts_in = 0, fifo_mode = 0, tx_enable = 0;
  logic tx_hold_full = 0, tx_shift_busy = 0, tx_brk_pending = 0, thr_write = 0;
  logic tx_fifo_full = 0, rx_enable = 0, rx_char_done = 0, rhr_read = 0;
  logic rx_fifo_empty = 1, rd_strobe = 0;
  logic [31:0] status_word, rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    bit          use_rd;
    logic [31:0] mask;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  uart_stat_word uut (
    .clk(clk), .rst_n(rst_n), .ev_manch_err(ev_manch_err), .ev_cmp_match(ev_cmp_match),
    .ev_parity_err(ev_parity_err), .ev_frame_err(ev_frame_err), .ev_overrun(ev_overrun),
    .ev_break(ev_break), .ev_nack(ev_nack), .ev_iter_limit(ev_iter_limit),
    .ev_timeout(ev_timeout), .tout_reload_zero(tout_reload_zero),
    .cmd_clr_status(cmd_clr_status), .cmd_clr_nack(cmd_clr_nack),
    .cmd_clr_iter(cmd_clr_iter), .cmd_start_timeout(cmd_start_timeout), .cts_in(cts_in),
    .fifo_mode(fifo_mode), .tx_enable(tx_enable), .tx_hold_full(tx_hold_full),
    .tx_shift_busy(tx_shift_busy), .tx_brk_pending(tx_brk_pending),
    .thr_write(thr_write), .tx_fifo_full(tx_fifo_full), .rx_enable(rx_enable),
    .rx_char_done(rx_char_done), .rhr_read(rhr_read), .rx_fifo_empty(rx_fifo_empty),
    .rd_strobe(rd_strobe), .status_word(status_word), .rd_data(rd_data));

  // monitor: compare after each active edge has settled
  always @(posedge clk) begin
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = sb.pop_front();
      act = e.use_rd ? rd_data : status_word;
      checks++;
      if ((act & e.mask) != (e.val & e.mask)) begin
        errors++;
        $display("FAIL %s %s actual=%h expected=%h mask=%h", e.tag,
                 e.use_rd ? "rd_data" : "status_word", act & e.mask, e.val & e.mask, e.mask);
      end
    end
  end

  task automatic exp_w(input logic [31:0] m, input logic [31:0] v, input string t);
    exp_t e;
    e.use_rd = 0; e.mask = m; e.val = v; e.tag = t;
    sb.push_back(e);
  endtask

  task automatic exp_r(input logic [31:0] m, input logic [31:0] v, input string t);
    exp_t e;
    e.use_rd = 1; e.mask = m; e.val = v; e.tag = t;
    sb.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
    {ev_manch_err, ev_cmp_match, ev_parity_err, ev_frame_err, ev_overrun, ev_break} = '0;
    {ev_nack, ev_iter_limit, ev_timeout, cmd_clr_status, cmd_clr_nack, cmd_clr_iter} = '0;
    {cmd_start_timeout, thr_write, rx_char_done, rhr_read, rd_strobe} = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    exp_w(ALL, 32'h0, "R1 reset"); step();

    ev_parity_err = 1; ev_overrun = 1;
    exp_w(PAR | OVR, PAR | OVR, "R2 set"); step();
    exp_w(PAR | OVR, PAR | OVR, "R2 hold"); step();
    cmd_clr_nack = 1; cmd_clr_iter = 1; cmd_start_timeout = 1;
    exp_w(PAR | OVR, PAR | OVR, "R2 other clears ignored"); step();
    cmd_clr_status = 1; ev_frame_err = 1;
    exp_w(PAR | OVR | FRM, FRM, "R2 clear with set-wins"); step();
    cmd_clr_status = 1;
    exp_w(GEN, 32'h0, "R2 clear"); step();

    ev_manch_err = 1; ev_cmp_match = 1; ev_parity_err = 1; ev_frame_err = 1;
    ev_overrun = 1; ev_break = 1; ev_nack = 1; ev_iter_limit = 1;
    exp_w(ALL, GEN | NACK | ITER, "R1 full word layout"); step();

    cmd_clr_status = 1;
    exp_w(ALL, NACK | ITER, "R3 survive general clear"); step();
    cmd_clr_iter = 1; ev_iter_limit = 1;
    exp_w(NACK | ITER, NACK | ITER, "R3 iter set-wins"); step();
    cmd_clr_nack = 1;
    exp_w(NACK | ITER, ITER, "R3 nack clear"); step();
    cmd_clr_iter = 1;
    exp_w(ITER, 32'h0, "R3 iter clear"); step();

    cts_in = 1;
    exp_w(CTS | CHG, 32'h0, "R4 sync stage1"); step();
    exp_w(CTS | CHG, CTS, "R4 level"); step();
    exp_w(CTS | CHG, CTS | CHG, "R4 change flag"); step();
    rd_strobe = 1;
    exp_w(CHG, 32'h0, "R4 clear on read");
    exp_r(CTS | CHG, CTS | CHG, "R11 capture"); step();
    exp_w(CHG, 32'h0, "R4 stays clear");
    exp_r(CTS | CHG, CTS | CHG, "R11 hold"); step();
    cts_in = 0;
    exp_w(CTS, CTS, "R4 falling stage1"); step();
    exp_w(CTS | CHG, 32'h0, "R4 falling level"); step();
    rd_strobe = 1;
    exp_w(CHG, CHG, "R4 edge beats read");
    exp_r(CTS | CHG, 32'h0, "R11 pre-edge capture"); step();
    rd_strobe = 1;
    exp_w(CHG, 32'h0, "R4 second read clears");
    exp_r(CHG, CHG, "R11 capture set"); step();

    cmd_start_timeout = 1;
    exp_w(TOUT, 32'h0, "R5 armed"); step();
    ev_timeout = 1;
    exp_w(TOUT, TOUT, "R5 expiry"); step();
    exp_w(TOUT, TOUT, "R5 hold"); step();
    cmd_start_timeout = 1;
    exp_w(TOUT, 32'h0, "R5 restart clears"); step();
    tout_reload_zero = 1; ev_timeout = 1;
    exp_w(TOUT, 32'h0, "R5 zero reload"); step();
    tout_reload_zero = 0;

    tx_enable = 1;
    exp_w(TXE | TXR, TXE | TXR, "R6 R7 enabled idle"); step();
    thr_write = 1;
    exp_w(TXE | TXR, 32'h0, "R6 R7 write clears"); step();
    tx_hold_full = 1;
    exp_w(TXE | TXR, 32'h0, "R7 char held"); step();
    tx_hold_full = 0; tx_shift_busy = 1;
    exp_w(TXE | TXR, TXR, "R6 shifting"); step();
    tx_shift_busy = 0; tx_brk_pending = 1;
    exp_w(TXE | TXR, TXE, "R7 break pending"); step();
    tx_brk_pending = 0; tx_enable = 0;
    exp_w(TXE | TXR, 32'h0, "R6 R7 disabled"); step();

    fifo_mode = 1;
    exp_w(TXE | TXR, TXR, "R8 fifo not full while disabled"); step();
    tx_fifo_full = 1;
    exp_w(TXR, 32'h0, "R8 fifo full"); step();
    tx_fifo_full = 0; rx_fifo_empty = 0;
    exp_w(RXR, RXR, "R10 fifo data"); step();
    rx_fifo_empty = 1;
    exp_w(RXR, 32'h0, "R10 fifo empty"); step();

    fifo_mode = 0; rx_char_done = 1;
    exp_w(RXR, 32'h0, "R9 rx disabled"); step();
    exp_w(RXR, 32'h0, "R9 still hidden"); step();
    rx_enable = 1;
    exp_w(RXR, RXR, "R9 appears on enable"); step();
    rhr_read = 1; rx_char_done = 1;
    exp_w(RXR, RXR, "R9 completion beats read"); step();
    rhr_read = 1;
    exp_w(RXR, 32'h0, "R9 read clears"); step();
    rx_char_done = 1;
    exp_w(RXR, RXR, "R9 enabled receive"); step();

    step(); step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule